// File: doc/BRIEF.md
# Serial DAC Command Sequencer

This block sits on the host side of an eight-channel serial voltage DAC. It takes one request at a time from a valid/ready stream. Each request names a channel, a gain-range flag and an 8-bit code. The block turns the request into a 12-bit serial frame and drives the DAC's shift clock, data line, load strobe and update strobe. Every bus interval comes from cycle counters on the system clock. Each interval is a minimum time given in nanoseconds as a parameter, and the block rounds it up to whole system clock periods.

There are two modes. When `batch_i` is low, the update strobe stays low, so each load pulse moves its word straight to the addressed output. When `batch_i` is high, the update strobe stays high while any number of words are loaded. A commit request then produces one update pulse, and all outputs change together. A commit can be raised alone while the block is idle, together with a word, or at any time while a word is being sent. In the last two cases the update pulse follows that word's load pulse.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: Each accepted request produces exactly 12 falling shift-clock edges before its load pulse. The frame is sent MSB first, and its bits are: 11..9 = channel, 8 = range flag, 7..0 = code.
- R2: The data line changes only at a rising shift-clock edge or at acceptance, never while the shift clock is low after a falling edge. Before and after each falling edge it holds its value for at least HALF_CYC system cycles, where HALF_CYC = max(ceil(half shift period), ceil(setup), ceil(valid time)). This is 50 cycles at the defaults.
- R3: Successive falling shift-clock edges are at least 2*HALF_CYC cycles apart, which keeps the shift rate at or below 1 MHz at the defaults.
- R4: The load strobe stays high through shifting. It falls only with the shift clock low and no earlier than HALF_CYC cycles after the 12th falling edge. The shift clock stays low while the load strobe is low.
- R5: The load strobe stays low for exactly ceil(250 ns / clock period) cycles, which is 25 at the defaults.
- R6: In immediate mode the update strobe stays low, and each load pulse updates only the addressed output.
- R7: In batch mode the update strobe stays high while words are loaded, and no output changes. A commit raised while idle gives one update low pulse of exactly ceil(250 ns / clock period) cycles (25 at the defaults), and all outputs then take their loaded values.
- R8: A commit raised with a word, or while that word is in flight, gives one update pulse. That pulse falls in the same cycle the load strobe returns high, never before.
- R9: `req_ready_o` is high only when the block is idle. It goes low in the cycle after acceptance and stays low until the load pulse and any update pulse have ended.
- R10: A commit raised in immediate mode is ignored: the update strobe stays low and no pulse is generated.
- R11: After reset, `req_ready_o` is 1, the load strobe is 1, the shift clock is 0 and the update strobe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_chan_i | input | 3 | Target channel |
| req_range_i | input | 1 | Gain range flag (0 = x1, 1 = x2) |
| req_code_i | input | 8 | Output code |
| batch_i | input | 1 | 1 = batch mode, 0 = immediate mode; sampled while idle |
| commit_i | input | 1 | Request a simultaneous update (batch mode) |
| dac_clk_o | output | 1 | Serial shift clock, DAC samples on falling edge |
| dac_data_o | output | 1 | Serial data |
| dac_load_o | output | 1 | Load strobe, active-low pulse |
| dac_ldac_o | output | 1 | Update strobe, level or active-low pulse |

## Verification
A commit can arrive in the same cycle as a word is accepted, or in a cycle while that word is still shifting. In both cases the commit and the word's load pulse compete for the same end-of-word window. The bench raises the commit together with a word, and in a separate test raises it part way through a frame. A monitor models the DAC's input latches and outputs. It judges the result by checking that exactly one update fall occurs, with the load strobe already high, and that the modelled outputs then include the new word. A commit raised while the block is idle in immediate mode is also provoked, to show that it produces no pulse.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_LOADP,
    ST_LDACP
  } seq_state_e;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dac_cmd_timer.sv
module dac_cmd_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/dac_cmd_shifter.sv
module dac_cmd_shifter #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               adv_i,
  input  logic               fall_i,
  output logic               bit_o,
  output logic               last_o
);
  localparam int unsigned BC_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q;
  logic [BC_W-1:0]    left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sr_q   <= word_i;
      left_q <= BC_W'(FRAME_W);
    end else begin
      if (adv_i)                     sr_q   <= {sr_q[FRAME_W-2:0], 1'b0};
      if (fall_i && left_q != '0)    left_q <= left_q - 1'b1;
    end
  end

  assign bit_o  = sr_q[FRAME_W-1];
  assign last_o = (left_q == '0);
endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned SCLK_MAX_KHZ  = 1000,
  parameter int unsigned T_SU_NS       = 50,
  parameter int unsigned T_VAL_NS      = 50,
  parameter int unsigned T_LOADW_NS    = 250,
  parameter int unsigned T_LDACW_NS    = 250,
  parameter int unsigned CHAN_W        = 3,
  parameter int unsigned CODE_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [CHAN_W-1:0] req_chan_i,
  input  logic              req_range_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              batch_i,
  input  logic              commit_i,
  output logic              dac_clk_o,
  output logic              dac_data_o,
  output logic              dac_load_o,
  output logic              dac_ldac_o
);
  localparam int unsigned FRAME_W   = CHAN_W + 1 + CODE_W;
  localparam int unsigned HALF_NS   = (1_000_000 + 2*SCLK_MAX_KHZ - 1) / (2*SCLK_MAX_KHZ);
  localparam int unsigned HALF_CYC  = max3(ns_to_cyc(HALF_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_SU_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_VAL_NS, CLK_PERIOD_NS));
  localparam int unsigned LOAD_CYC  = ns_to_cyc(T_LOADW_NS, CLK_PERIOD_NS);
  localparam int unsigned LDAC_CYC  = ns_to_cyc(T_LDACW_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC   = max3(HALF_CYC, LOAD_CYC, LDAC_CYC);
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_e state_q, state_n;
  logic clk_q, clk_n, load_q, load_n, ldac_q, ldac_n;
  logic pend_q, pend_n, mode_q, mode_n;
  logic tmr_ld, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic sh_ld, sh_adv, sh_fall, sh_last, sh_bit;
  logic commit_hit;

  dac_cmd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_ld),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  dac_cmd_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sh_ld),
    .word_i ({req_chan_i, req_range_i, req_code_i}),
    .adv_i  (sh_adv),
    .fall_i (sh_fall),
    .bit_o  (sh_bit),
    .last_o (sh_last)
  );

  assign commit_hit = commit_i && mode_q;

  always_comb begin
    state_n = state_q;
    clk_n   = clk_q;
    load_n  = load_q;
    ldac_n  = ldac_q;
    mode_n  = mode_q;
    pend_n  = pend_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    sh_ld   = 1'b0;
    sh_adv  = 1'b0;
    sh_fall = 1'b0;
    if (state_q != ST_IDLE) pend_n = pend_q | commit_hit;
    unique case (state_q)
      ST_IDLE: begin
        ldac_n = batch_i;
        mode_n = batch_i;
        pend_n = 1'b0;
        if (req_valid_i) begin
          sh_ld   = 1'b1;
          pend_n  = commit_i && batch_i;
          state_n = ST_LEAD;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(HALF_CYC - 1);
        end else if (commit_i && batch_i && mode_q) begin
          ldac_n  = 1'b0;
          state_n = ST_LDACP;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(LDAC_CYC - 1);
        end
      end
      ST_LEAD: if (tmr_done) begin
        clk_n   = 1'b1;
        state_n = ST_HIGH;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(HALF_CYC - 1);
      end
      ST_HIGH: if (tmr_done) begin
        clk_n   = 1'b0;
        sh_fall = 1'b1;
        state_n = ST_LOW;
        tmr_ld  = 1'b1;
        tmr_val = CNT_W'(HALF_CYC - 1);
      end
      ST_LOW: if (tmr_done) begin
        tmr_ld = 1'b1;
        if (sh_last) begin
          load_n  = 1'b0;
          state_n = ST_LOADP;
          tmr_val = CNT_W'(LOAD_CYC - 1);
        end else begin
          clk_n   = 1'b1;
          sh_adv  = 1'b1;
          state_n = ST_HIGH;
          tmr_val = CNT_W'(HALF_CYC - 1);
        end
      end
      ST_LOADP: if (tmr_done) begin
        load_n = 1'b1;
        if (mode_q && (pend_q || commit_i)) begin
          ldac_n  = 1'b0;
          state_n = ST_LDACP;
          tmr_ld  = 1'b1;
          tmr_val = CNT_W'(LDAC_CYC - 1);
        end else begin
          state_n = ST_IDLE;
        end
      end
      ST_LDACP: if (tmr_done) begin
        ldac_n  = 1'b1;
        pend_n  = 1'b0;
        state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      clk_q   <= 1'b0;
      load_q  <= 1'b1;
      ldac_q  <= 1'b0;
      pend_q  <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      clk_q   <= clk_n;
      load_q  <= load_n;
      ldac_q  <= ldac_n;
      pend_q  <= pend_n;
      mode_q  <= mode_n;
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign dac_clk_o   = clk_q;
  assign dac_data_o  = sh_bit;
  assign dac_load_o  = load_q;
  assign dac_ldac_o  = ldac_q;
endmodule

// File: rtl/dac_cmd_chk.sv
module dac_cmd_chk #(
  parameter int unsigned LOAD_CYC = 25,
  parameter int unsigned LDAC_CYC = 25
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic dac_clk_o,
  input logic dac_data_o,
  input logic dac_load_o,
  input logic dac_ldac_o
);
  logic [15:0] load_lo_q, ldac_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_lo_q <= '0;
      ldac_lo_q <= '0;
    end else begin
      load_lo_q <= dac_load_o ? '0 : ((load_lo_q == 16'hFFFF) ? load_lo_q : load_lo_q + 1'b1);
      ldac_lo_q <= dac_ldac_o ? '0 : ((ldac_lo_q == 16'hFFFF) ? ldac_lo_q : ldac_lo_q + 1'b1);
    end
  end

  AST_DATA_STILL_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_clk_o && $past(!dac_clk_o) && !$past(req_ready_o)) |-> $stable(dac_data_o)); // R2
  AST_CLK_LOW_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_load_o |-> !dac_clk_o); // R4
  AST_CLK_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_clk_o |-> !req_ready_o); // R4
  AST_LOAD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_load_o) |-> (load_lo_q >= 16'(LOAD_CYC))); // R5
  AST_UPDATE_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_ldac_o) |-> dac_load_o); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R9
  AST_NOT_READY_IN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_load_o |-> !req_ready_o); // R9
  AST_UPDATE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dac_ldac_o) && ldac_lo_q <= 16'(4*LDAC_CYC)) |-> (ldac_lo_q >= 16'(LDAC_CYC))); // R7
endmodule

bind dac_cmd_ctrl dac_cmd_chk #(.LOAD_CYC(LOAD_CYC), .LDAC_CYC(LDAC_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .dac_clk_o   (dac_clk_o),
  .dac_data_o  (dac_data_o),
  .dac_load_o  (dac_load_o),
  .dac_ldac_o  (dac_ldac_o)
);

// File: tb/sim_dac_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_dac_cmd_ctrl;
  localparam int HALF  = 50;
  localparam int LOADW = 25;
  localparam int LDACW = 25;

  logic clk = 0, rst_n = 0;
  logic valid = 0, batch = 0, commit = 0, rng = 0;
  logic [2:0] chan = 0;
  logic [7:0] code = 0;
  logic ready, dclk, ddata, dload, dldac;

  always #5 clk = ~clk;

  dac_cmd_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_chan_i(chan), .req_range_i(rng), .req_code_i(code),
    .batch_i(batch), .commit_i(commit),
    .dac_clk_o(dclk), .dac_data_o(ddata), .dac_load_o(dload), .dac_ldac_o(dldac)
  );

  int n_chk = 0, n_fail = 0;
  logic [8:0] dev_latch [8];
  logic [8:0] dev_out   [8];
  logic [8:0] exp_latch [8];
  logic [8:0] exp_out   [8];
  logic [11:0] exp_frame = '0;
  logic [11:0] rx_word = '0;
  int rx_bits = 0, ldac_falls = 0;
  int c_data = 0, c_fall = 0, c_load = 0, c_ldac = 0;
  logic p_clk = 0, p_data = 0, p_load = 1, p_ldac = 0, pulse_flag = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial for (int i = 0; i < 8; i++) begin
    dev_latch[i] = '0; dev_out[i] = '0; exp_latch[i] = '0; exp_out[i] = '0;
  end

  // bus monitor and DAC model
  always @(negedge clk) if (rst_n) begin
    if (p_clk && !dclk) begin
      chk(dload, "R4", "load high at shift edge", dload, 1);
      chk(c_data >= HALF, "R2", "data setup cycles", c_data, HALF);
      if (rx_bits > 0) chk(c_fall >= 2*HALF, "R3", "fall-to-fall cycles", c_fall, 2*HALF);
      rx_word = {rx_word[10:0], ddata};
      rx_bits++;
    end
    if (ddata != p_data && rx_bits > 0 && dload)
      chk(c_fall >= HALF, "R2", "data valid after fall", c_fall, HALF);
    if (p_load && !dload) begin
      chk(rx_bits == 12, "R1", "edges per frame", rx_bits, 12);
      chk(rx_word == exp_frame, "R1", "frame bits", rx_word, exp_frame);
      chk(c_fall >= HALF && !dclk, "R4", "last edge to load", c_fall, HALF);
      dev_latch[rx_word[11:9]] = rx_word[8:0];
      if (!dldac) dev_out[rx_word[11:9]] = rx_word[8:0];
      rx_bits = 0;
    end
    if (!p_load && dload) chk(c_load == LOADW, "R5", "load width", c_load, LOADW);
    if (p_ldac && !dldac) begin
      chk(dload, "R8", "load high at update fall", dload, 1);
      ldac_falls++;
      pulse_flag = batch;
      for (int i = 0; i < 8; i++) dev_out[i] = dev_latch[i];
    end
    if (!p_ldac && dldac && pulse_flag) begin
      chk(c_ldac == LDACW, "R7", "update width", c_ldac, LDACW);
      pulse_flag = 0;
    end
    c_data = (ddata != p_data) ? 1 : c_data + 1;
    c_fall = (p_clk && !dclk) ? 1 : c_fall + 1;
    c_load = (p_load && !dload) ? 1 : c_load + 1;
    c_ldac = (p_ldac && !dldac) ? 1 : c_ldac + 1;
    p_clk = dclk; p_data = ddata; p_load = dload; p_ldac = dldac;
  end

  task automatic wait_idle();
    @(negedge clk);
    while (!ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] c, input logic r, input logic [7:0] d, input logic with_commit);
    @(negedge clk);
    chan = c; rng = r; code = d; valid = 1; commit = with_commit;
    exp_frame = {c, r, d};
    exp_latch[c] = {r, d};
    if (!batch) exp_out[c] = {r, d};
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 0; commit = 0;
    chk(!ready, "R9", "ready after accept", ready, 0);
  endtask

  task automatic cmp_outputs(input string req);
    for (int i = 0; i < 8; i++)
      chk(dev_out[i] == exp_out[i], req, $sformatf("output ch%0d", i), dev_out[i], exp_out[i]);
  endtask

  task automatic t_reset();
    chk(ready == 1, "R11", "ready", ready, 1);
    chk(dload == 1, "R11", "load", dload, 1);
    chk(dclk == 0, "R11", "shift clk", dclk, 0);
    chk(dldac == 0, "R11", "update", dldac, 0);
  endtask

  task automatic t_immediate();
    int f0 = ldac_falls;
    batch = 0;
    send(3'd2, 1'b0, 8'h5A, 0); wait_idle();
    send(3'd0, 1'b1, 8'hFF, 0); wait_idle();
    send(3'd7, 1'b1, 8'h00, 0); wait_idle();
    send(3'd5, 1'b0, 8'h81, 0); wait_idle();
    cmp_outputs("R6");
    chk(dldac == 0 && ldac_falls == f0, "R6", "update stays low", ldac_falls - f0, 0);
  endtask

  task automatic t_ignore_commit();
    int f0 = ldac_falls;
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    repeat (40) @(negedge clk);
    chk(ldac_falls == f0 && dldac == 0, "R10", "no update pulse", ldac_falls - f0, 0);
    chk(ready == 1, "R10", "still idle", ready, 1);
  endtask

  task automatic t_batch();
    int f0;
    @(negedge clk); batch = 1;
    repeat (3) @(negedge clk);
    chk(dldac == 1, "R7", "update high in batch", dldac, 1);
    f0 = ldac_falls;
    send(3'd1, 1'b0, 8'h11, 0); wait_idle();
    send(3'd6, 1'b1, 8'hC3, 0); wait_idle();
    send(3'd2, 1'b1, 8'h7F, 0); wait_idle();
    cmp_outputs("R7");
    chk(ldac_falls == f0, "R7", "no update while loading", ldac_falls - f0, 0);
    @(negedge clk); commit = 1;
    @(negedge clk); commit = 0;
    chk(!ready, "R9", "busy during update", ready, 0);
    for (int i = 0; i < 8; i++) exp_out[i] = exp_latch[i];
    wait_idle();
    cmp_outputs("R7");
    chk(ldac_falls == f0 + 1, "R7", "one update pulse", ldac_falls - f0, 1);
  endtask

  task automatic t_commit_with_word();
    int f0 = ldac_falls;
    send(3'd4, 1'b0, 8'h96, 1);
    for (int i = 0; i < 8; i++) exp_out[i] = exp_latch[i];
    wait_idle();
    cmp_outputs("R8");
    chk(ldac_falls == f0 + 1, "R8", "pulse count with word", ldac_falls - f0, 1);
  endtask

  task automatic t_commit_mid_frame();
    int f0 = ldac_falls;
    send(3'd3, 1'b1, 8'h3C, 0);
    repeat (300) @(negedge clk);
    commit = 1;
    @(negedge clk); commit = 0;
    for (int i = 0; i < 8; i++) exp_out[i] = exp_latch[i];
    wait_idle();
    cmp_outputs("R8");
    chk(ldac_falls == f0 + 1, "R8", "pulse count mid frame", ldac_falls - f0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_immediate();
    t_ignore_commit();
    t_batch();
    t_commit_with_word();
    t_commit_mid_frame();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule